// File: doc/BRIEF.md
# Stereo Audio Codec Serial Link

This block connects a host's parallel sample registers to a 20-bit stereo audio converter over a serial link. A single free-running sequence counter, clocked by the input clock, produces all the timing. The converter's master clock runs at half the input rate. The serial bit clock is one quarter of the master clock. The frame clock selects the active channel, and each channel slot lasts 32 bit periods. Each bit period is split into four master-clock subcycles. Incoming converter data is captured in subcycle 2. Outgoing data changes at the start of subcycle 0, so it is steady when the converter samples it.

For each channel the host sees a holding register for the digitised input and a holding register for the output sample, and each has a ready flag. A channel-select input chooses which channel a read or a write reaches. At the first bit of each slot the block checks the active channel. If the last input word is still unread, it flags an overrun. If no output word has been written, it flags an underrun. The left and right flags are ORed onto two error outputs. The three clock outputs leave the block complemented, to suit an external inverting buffer.

Top module: `codec_link`

## Requirements
- R1: Let n be the number of rising input-clock edges since reset was released. Then `mclk_out` is ~n[0], `bclk_out` is ~n[2] and `frame_out` is ~n[8]. `frame_out` high (n[8]=0) marks the left slot (channel 0), and `frame_out` low marks the right slot (channel 1).
- R2: In the active slot, bits 0 to 19 of `sdata_in` are taken MSB first. Each bit is taken on the edge at the end of subcycle 2 (n[2:1]=2, n[0]=0). After bit 19, the word moves to that channel's input holding register and `adc_ready[ch]` sets.
- R3: `rdata` always shows the input holding register picked by `sel` (0 left, 1 right). A cycle with `rd` high clears `adc_ready[sel]` on the next edge, unless a new word lands in that same cycle.
- R4: A cycle with `wr` high and `dac_ready[sel]`=1 stores `wdata` and clears `dac_ready[sel]`. A write while `dac_ready[sel]`=0 is ignored, and the stored word is kept.
- R5: At the first edge of a channel's slot, its written word is loaded for sending and `dac_ready[ch]` sets again. `sdata_out` carries the word MSB first, one bit per bit period. Each bit changes only after the edge that starts subcycle 0, and bits 20 to 31 of the slot are 0.
- R6: At the first edge of a slot, the channel's underrun flag becomes `dac_ready[ch]`. If the flag is set, zeros are sent for that slot. `underrun` is the OR of both channels' flags.
- R7: At the first edge of a slot, the channel's overrun flag becomes `adc_ready[ch]`. A newly captured word overwrites an unread one. `overrun` is the OR of both channels' flags.
- R8: While reset is held, `adc_ready` is 00, `dac_ready` is 11, both error outputs are 0, `sdata_out` is 0, and the clock outputs are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, the source of every derived clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata_in | input | 1 | Serial data from the converter's input side |
| sel | input | 1 | Channel select for host access: 0 left, 1 right |
| rd | input | 1 | Read strobe; consumes the selected input word |
| wr | input | 1 | Write strobe for the selected output word |
| wdata | input | 20 | Output sample to write |
| rdata | output | 20 | Input sample of the selected channel |
| adc_ready | output | 2 | Per-channel unread-input flags, bit 0 left |
| dac_ready | output | 2 | Per-channel output-empty flags, bit 0 left |
| overrun | output | 1 | OR of the per-channel overrun flags |
| underrun | output | 1 | OR of the per-channel underrun flags |
| sdata_out | output | 1 | Serial data to the converter's output side |
| mclk_out | output | 1 | Complemented master clock |
| bclk_out | output | 1 | Complemented serial bit clock |
| frame_out | output | 1 | Complemented left/right frame clock |

## Verification
On every cycle, the assertions check the following:
- the ready flag of each channel reacts to captures, reads, writes and slot starts;
- each error flag follows the ready flag at the slot boundary;
- `sdata_out` moves only on launch or load edges;
- the master clock toggles.

Only the bench scenarios can show the remaining behaviour. These are the bit order and content of whole words in both directions, that a rejected write leaves the sent word unchanged, that an overrun keeps the newest word, that an unwritten slot sends zeros, and the exact phase of the three clock outputs against the edge count.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;
  localparam int NUM_CH = 2;
  localparam logic [1:0] SUB_LAUNCH  = 2'd0;  // output bit changes here
  localparam logic [1:0] SUB_CAPTURE = 2'd2;  // input bit taken here
endpackage

// File: rtl/codec_link_timing.sv
module codec_link_timing
  import codec_link_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int SLOT_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic side,
  output logic slot_start,
  output logic launch,
  output logic capture,
  output logic last_capture,
  output logic mclk_int,
  output logic bclk_int,
  output logic frame_int
);
  // seq layout: [0] master phase, [2:1] subcycle, [SLOT_LOG2+2:3] bit, top side
  localparam int SEQ_W = SLOT_LOG2 + 4;

  logic [SEQ_W-1:0] seq_q;

  function automatic logic [1:0] sub_of(input logic [SEQ_W-1:0] s);
    return s[2:1];
  endfunction

  function automatic logic [SLOT_LOG2-1:0] bit_of(input logic [SEQ_W-1:0] s);
    return s[SLOT_LOG2+2:3];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= '0;
    else        seq_q <= seq_q + 1'b1;
  end

  logic                 edge0;
  logic [1:0]           sub;
  logic [SLOT_LOG2-1:0] bitn;

  assign edge0 = ~seq_q[0];
  assign sub   = sub_of(seq_q);
  assign bitn  = bit_of(seq_q);

  assign slot_start   = edge0 && (sub == SUB_LAUNCH) && (bitn == '0);
  assign launch       = edge0 && (sub == SUB_LAUNCH) && (bitn != '0);
  assign capture      = edge0 && (sub == SUB_CAPTURE) && (int'(bitn) < SAMPLE_W);
  assign last_capture = capture && (int'(bitn) == SAMPLE_W - 1);

  assign side      = seq_q[SEQ_W-1];
  assign mclk_int  = seq_q[0];
  assign bclk_int  = seq_q[2];
  assign frame_int = seq_q[SEQ_W-1];
endmodule

// File: rtl/codec_link_adc.sv
module codec_link_adc
  import codec_link_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                side,
  input  logic                capture,
  input  logic                last_capture,
  input  logic                slot_start,
  input  logic                sdata_in,
  input  logic                rd,
  input  logic                sel,
  output logic [SAMPLE_W-1:0] rdata,
  output logic [NUM_CH-1:0]   ready,
  output logic                overrun
);
  logic [SAMPLE_W-1:0] sr_q;
  logic [SAMPLE_W-1:0] hold_q [NUM_CH];
  logic [NUM_CH-1:0]   rdy_q;
  logic [NUM_CH-1:0]   ovr_q;
  logic [SAMPLE_W-1:0] word_in;

  assign word_in = {sr_q[SAMPLE_W-2:0], sdata_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      rdy_q <= '0;
      ovr_q <= '0;
      for (int c = 0; c < NUM_CH; c++) hold_q[c] <= '0;
    end else begin
      if (capture) sr_q <= word_in;
      for (int c = 0; c < NUM_CH; c++) begin
        if (last_capture && int'(side) == c) begin
          hold_q[c] <= word_in;
          rdy_q[c]  <= 1'b1;
        end else if (rd && int'(sel) == c) begin
          rdy_q[c] <= 1'b0;
        end
        if (slot_start && int'(side) == c) ovr_q[c] <= rdy_q[c];
      end
    end
  end

  assign rdata   = hold_q[sel];
  assign ready   = rdy_q;
  assign overrun = |ovr_q;
endmodule

// File: rtl/codec_link_dac.sv
module codec_link_dac
  import codec_link_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                side,
  input  logic                slot_start,
  input  logic                launch,
  input  logic                wr,
  input  logic                sel,
  input  logic [SAMPLE_W-1:0] wdata,
  output logic [NUM_CH-1:0]   ready,
  output logic                underrun,
  output logic                sdata_out
);
  logic [NUM_CH-1:0][SAMPLE_W-1:0] hold_all;
  logic [NUM_CH-1:0]               und;
  logic [SAMPLE_W-1:0]             sr_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] hold_q;
    logic                rdy_q;
    logic                und_q;
    logic                mine_start;

    assign mine_start = slot_start && (side == 1'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        rdy_q  <= 1'b1;
        und_q  <= 1'b0;
      end else if (mine_start) begin
        und_q <= rdy_q;
        rdy_q <= 1'b1;
      end else if (wr && sel == 1'(c) && rdy_q) begin
        hold_q <= wdata;
        rdy_q  <= 1'b0;
      end
    end

    assign hold_all[c] = hold_q;
    assign ready[c]    = rdy_q;
    assign und[c]      = und_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= '0;
    else if (slot_start) sr_q <= ready[side] ? '0 : hold_all[side];
    else if (launch)     sr_q <= {sr_q[SAMPLE_W-2:0], 1'b0};
  end

  assign sdata_out = sr_q[SAMPLE_W-1];
  assign underrun  = |und;
endmodule

// File: rtl/codec_link.sv
module codec_link
  import codec_link_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int SLOT_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdata_in,
  input  logic                sel,
  input  logic                rd,
  input  logic                wr,
  input  logic [SAMPLE_W-1:0] wdata,
  output logic [SAMPLE_W-1:0] rdata,
  output logic [NUM_CH-1:0]   adc_ready,
  output logic [NUM_CH-1:0]   dac_ready,
  output logic                overrun,
  output logic                underrun,
  output logic                sdata_out,
  output logic                mclk_out,
  output logic                bclk_out,
  output logic                frame_out
);
  logic side_w, slot_start_w, launch_w, capture_w, last_capture_w;
  logic mclk_w, bclk_w, frame_w;

  codec_link_timing #(.SAMPLE_W(SAMPLE_W), .SLOT_LOG2(SLOT_LOG2)) u_timing (
    .clk(clk), .rst_n(rst_n), .side(side_w), .slot_start(slot_start_w),
    .launch(launch_w), .capture(capture_w), .last_capture(last_capture_w),
    .mclk_int(mclk_w), .bclk_int(bclk_w), .frame_int(frame_w)
  );

  codec_link_adc #(.SAMPLE_W(SAMPLE_W)) u_adc (
    .clk(clk), .rst_n(rst_n), .side(side_w), .capture(capture_w),
    .last_capture(last_capture_w), .slot_start(slot_start_w),
    .sdata_in(sdata_in), .rd(rd), .sel(sel), .rdata(rdata),
    .ready(adc_ready), .overrun(overrun)
  );

  codec_link_dac #(.SAMPLE_W(SAMPLE_W)) u_dac (
    .clk(clk), .rst_n(rst_n), .side(side_w), .slot_start(slot_start_w),
    .launch(launch_w), .wr(wr), .sel(sel), .wdata(wdata),
    .ready(dac_ready), .underrun(underrun), .sdata_out(sdata_out)
  );

  // complemented for an inverting buffer between block and converter
  assign mclk_out  = ~mclk_w;
  assign bclk_out  = ~bclk_w;
  assign frame_out = ~frame_w;
endmodule

// File: rtl/codec_link_chk.sv
module codec_link_chk
  import codec_link_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              side,
  input logic              slot_start,
  input logic              launch,
  input logic              last_capture,
  input logic              rd,
  input logic              wr,
  input logic              sel,
  input logic [NUM_CH-1:0] adc_ready,
  input logic [NUM_CH-1:0] dac_ready,
  input logic              overrun,
  input logic              underrun,
  input logic              sdata_out,
  input logic              mclk_out
);
  p_mclk_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mclk_out != $past(mclk_out)));

  p_sdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_start && !launch) |=> $stable(sdata_out));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_capture_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (last_capture && side == 1'(c)) |=> adc_ready[c]);

    p_read_clears_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == 1'(c) && !(last_capture && side == 1'(c))) |=> !adc_ready[c]);

    p_full_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == 1'(c) && !dac_ready[c] && !(slot_start && side == 1'(c)))
      |=> !dac_ready[c]);

    p_slot_frees_dac_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && side == 1'(c)) |=> dac_ready[c]);

    p_underrun_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && side == 1'(c) && dac_ready[c]) |=> underrun);

    p_overrun_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && side == 1'(c) && adc_ready[c]) |=> overrun);
  end
endmodule

bind codec_link codec_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .side(side_w), .slot_start(slot_start_w),
  .launch(launch_w), .last_capture(last_capture_w), .rd(rd), .wr(wr),
  .sel(sel), .adc_ready(adc_ready), .dac_ready(dac_ready),
  .overrun(overrun), .underrun(underrun), .sdata_out(sdata_out),
  .mclk_out(mclk_out)
);

// File: tb/codec_link_test.sv
module codec_link_test;
  localparam int CLK_P = 10;
  localparam int W     = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sdata_in;
  logic         sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [1:0]   adc_ready, dac_ready;
  logic         overrun, underrun, sdata_out, mclk_out, bclk_out, frame_out;

  codec_link uut (
    .clk(clk), .rst_n(rst_n), .sdata_in(sdata_in), .sel(sel), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .adc_ready(adc_ready), .dac_ready(dac_ready),
    .overrun(overrun), .underrun(underrun), .sdata_out(sdata_out),
    .mclk_out(mclk_out), .bclk_out(bclk_out), .frame_out(frame_out)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, clk_err = 0;
  logic [8:0]   sm;
  logic [W-1:0] tx [2];
  logic [W-1:0] rx [2];
  logic [W-1:0] dac_exp [2];
  int           mb;
  logic         ms;

  // edge count since reset release, modelled from R1
  always @(posedge clk or negedge rst_n)
    if (!rst_n) sm <= '0;
    else        sm <= sm + 1'b1;

  // converter model: drives input bits, samples output bits
  always @(negedge clk) begin
    ms = sm[8];
    mb = int'(sm[7:3]);
    sdata_in = (rst_n && mb < W) ? tx[ms][W-1-mb] : 1'b0;
    if (rst_n) begin
      if ({mclk_out, bclk_out, frame_out} !== {~sm[0], ~sm[2], ~sm[8]}) clk_err++;
      if (sm[2:1] == 2'd2 && !sm[0] && mb < W) rx[ms][W-1-mb] = sdata_out;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_s(input int t);
    do @(negedge clk); while (int'(sm) != t);
  endtask

  task automatic read_ch(input logic c, output logic [W-1:0] v);
    sel = c; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic write_ch(input logic c, input logic [W-1:0] d);
    sel = c; wdata = d; wr = 1'b1;
    @(negedge clk) wr = 1'b0;
  endtask

  function automatic logic [W-1:0] pick(input int f, input int c);
    if (f == 1) return (c == 0) ? 20'h80000 : 20'h00001;
    if (f == 2) return (c == 0) ? 20'hFFFFF : 20'h00000;
    return W'($urandom);
  endfunction

  // standard frame step at n=480: check received words, read, write
  task automatic frame_step(input int f, input logic do_rd_l, input logic do_wr_r);
    logic [W-1:0] v;
    chk("R5 dac_ready both empty", 32'(dac_ready), 32'd3);
    if (f == 0) begin
      chk("R6 underrun after unwritten slots", 32'(underrun), 32'd1);
      chk("R6 zeros sent left", 32'(rx[0]), 32'd0);
      chk("R6 zeros sent right", 32'(rx[1]), 32'd0);
    end else if (f > 0) begin
      chk("R5 left word sent", 32'(rx[0]), 32'(dac_exp[0]));
      chk("R5 right word sent", 32'(rx[1]), 32'(dac_exp[1]));
    end
    if (do_rd_l) begin
      read_ch(1'b0, v);
      chk("R2 left word captured", 32'(v), 32'(tx[0]));
      chk("R3 left ready cleared by read", 32'(adc_ready[0]), 32'd0);
    end
    read_ch(1'b1, v);
    chk("R2 right word captured", 32'(v), 32'(tx[1]));
    chk("R3 right ready cleared by read", 32'(adc_ready[1]), 32'd0);
    dac_exp[0] = pick(f + 1, 0);
    write_ch(1'b0, dac_exp[0]);
    chk("R4 left write accepted", 32'(dac_ready[0]), 32'd0);
    if (do_wr_r) begin
      dac_exp[1] = pick(f + 1, 1);
      write_ch(1'b1, dac_exp[1]);
      chk("R4 right write accepted", 32'(dac_ready[1]), 32'd0);
    end
    if (f == 3) write_ch(1'b0, ~dac_exp[0]);  // R4: full, must be ignored
    tx[0] = pick(f + 1, 0) ^ 20'h5A5A5;
    tx[1] = pick(f + 1, 1) ^ 20'h3C3C3;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    tx[0] = 20'hA5F0C;
    tx[1] = 20'h13579;
    repeat (3) @(negedge clk);
    chk("R8 adc_ready in reset", 32'(adc_ready), 32'd0);
    chk("R8 dac_ready in reset", 32'(dac_ready), 32'd3);
    chk("R8 overrun in reset", 32'(overrun), 32'd0);
    chk("R8 underrun in reset", 32'(underrun), 32'd0);
    chk("R8 sdata_out in reset", 32'(sdata_out), 32'd0);
    chk("R8 clocks in reset", 32'({mclk_out, bclk_out, frame_out}), 32'd7);
    rst_n = 1'b1;

    for (int f = 0; f < 9; f++) begin
      wait_s(480);
      chk("R2 both input words ready", 32'(adc_ready), 32'd3);
      chk("R7 no overrun when read in time", 32'(overrun), 32'd0);
      if (f > 0) chk("R6 no underrun when written", 32'(underrun), 32'd0);
      frame_step(f, (f != 8), 1'b1);
    end

    // left input left unread in frame 8
    wait_s(100);
    chk("R7 overrun on unread left", 32'(overrun), 32'd1);
    chk("R6 no underrun", 32'(underrun), 32'd0);
    wait_s(480);
    frame_step(9, 1'b1, 1'b0);  // left read gets newest word; right not written
    wait_s(100);
    chk("R7 overrun cleared after read", 32'(overrun), 32'd0);
    chk("R6 underrun clear before right slot", 32'(underrun), 32'd0);
    wait_s(300);
    chk("R6 underrun on unwritten right", 32'(underrun), 32'd1);
    wait_s(480);
    chk("R6 right slot sent zeros", 32'(rx[1]), 32'd0);
    dac_exp[1] = 20'd0;
    frame_step(10, 1'b1, 1'b1);
    wait_s(300);
    chk("R6 underrun cleared after write", 32'(underrun), 32'd0);
    wait_s(480);
    chk("R5 right word after recovery", 32'(rx[1]), 32'(dac_exp[1]));
    chk("R1 clock outputs follow edge count", 32'(clk_err), 32'd0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule